// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a short record of finished transmissions for the host. The transmit engine reports each finished frame as a one-cycle completion event. The event carries a flag that says whether the frame asked for an interrupt on success, and three error flags: jabber, underrun and maximum collisions. Completions that matter are stored as status bytes in a small first-in first-out store. The oldest byte is shown on a byte-wide read port. A host write strobe to that port discards the byte shown and moves to the next one.

A completion that finds the store full is dropped, and the newest stored byte is marked as overflowed. A jabber or underrun error shuts the transmitter off until a transmit reset arrives. Separately, a pending flag tells the interrupt logic that status is waiting. The acknowledge input clears that flag.

Top module: `txstat_stack`

## Requirements
- R1: After reset, `stat_rdata` is 0x00, `tx_disabled` is 0 and `txc_pending` is 0. Whenever the store is empty, `stat_rdata` reads 0x00, with bit 7 clear.
- R2: A stored status byte has bit 7 = 1 (complete), bit 6 = interrupt-on-success requested, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = overflow, and bits 1..0 = 0.
- R3: A completion with no error flags is stored only when `cpl_irq_req` is 1. A completion with any error flag set is always stored.
- R4: Entries leave in arrival order. A stored completion becomes visible on `stat_rdata` right after the clock edge that samples it, provided it is the oldest entry.
- R5: A pulse on `stat_wr` removes the oldest entry. A `stat_wr` pulse while the store is empty changes nothing.
- R6: The store holds `DEPTH` entries (default 4). A storable completion that arrives while the store is full, with no pop in the same cycle, is lost, and bit 2 of the newest stored entry is set.
- R7: When the store is full and a pop and a storable completion fall in the same cycle, the pop is applied first. The new entry is then stored without overflow.
- R8: A stored completion that carries jabber or underrun sets `tx_disabled`. Only `tx_reset` clears it. While `tx_disabled` is 1, completions are ignored.
- R9: `tx_reset` empties the store and clears `tx_disabled`. A completion or a pop in the same cycle has no effect.
- R10: `txc_pending` sets on every accepted storable completion, including one that overflows, and clears on `ack_txc`. If both fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpl_valid | input | 1 | One-cycle completion event from the transmit engine |
| cpl_irq_req | input | 1 | Frame asked for an interrupt on success |
| cpl_jabber | input | 1 | Jabber error on this frame |
| cpl_underrun | input | 1 | Underrun error on this frame |
| cpl_maxcoll | input | 1 | Maximum-collision error on this frame |
| stat_wr | input | 1 | Host write to the status port; pops the oldest entry |
| tx_reset | input | 1 | Transmit reset: empties store, re-enables transmitter |
| ack_txc | input | 1 | Acknowledge of the completion-pending flag |
| stat_rdata | output | 8 | Oldest status byte, or 0x00 when empty |
| tx_disabled | output | 1 | Transmitter shut off by a jabber or underrun error |
| txc_pending | output | 1 | Completion status waiting for acknowledge |

## Verification
Two things can land in the same cycle: a host pop and a new completion while the store holds its last free slot or is full. The pop must take effect first, so that the completion is stored rather than marked as overflow. Directed sequences fill the store to `DEPTH` and then pulse `stat_wr` and `cpl_valid` together. The bench then checks the byte order and the absence of bit 2 as the entries are drained. Random traffic with frequent pops and completions creates this collision many times more. Every cycle is compared against a bench model that applies the pop before the push.

// File: rtl/txstat_pkg.sv
package txstat_pkg;
  localparam int STAT_W  = 8;
  localparam int OVF_BIT = 2;

  typedef struct packed {
    logic       done;
    logic       irq;
    logic       jab;
    logic       und;
    logic       mcol;
    logic       ovf;
    logic [1:0] rsvd;
  } txstat_t;
endpackage

// File: rtl/txstat_fmt.sv
module txstat_fmt
  import txstat_pkg::*;
(
  input  logic                 irq_req,
  input  logic                 jabber,
  input  logic                 underrun,
  input  logic                 maxcoll,
  output logic [STAT_W-1:0]    entry,
  output logic                 storable,
  output logic                 fatal
);
  txstat_t e;

  always_comb begin
    e.done = 1'b1;
    e.irq  = irq_req;
    e.jab  = jabber;
    e.und  = underrun;
    e.mcol = maxcoll;
    e.ovf  = 1'b0;
    e.rsvd = 2'b00;
  end

  assign entry    = e;
  assign fatal    = jabber | underrun;
  assign storable = irq_req | jabber | underrun | maxcoll;
endmodule

// File: rtl/txstat_store.sv
module txstat_store #(
  parameter int DEPTH   = 4,
  parameter int W       = 8,
  parameter int OVF_BIT = 2,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     rdata,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr, rd_nxt, newest;
  logic [CNT_W-1:0] cnt_nxt;
  logic             full, do_pop, do_push, do_ovf, we;
  logic [PTR_W-1:0] waddr;
  logic [W-1:0]     wdata, rdata_nxt;

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign do_push = push && (!full || do_pop);
  assign do_ovf  = push && full && !do_pop;
  assign newest  = (wr_ptr == '0) ? PTR_W'(DEPTH - 1) : wr_ptr - 1'b1;
  assign we      = (do_push || do_ovf) && !clr;
  assign waddr   = do_ovf ? newest : wr_ptr;
  assign wdata   = do_ovf ? (mem[newest] | W'(1 << OVF_BIT)) : din;
  assign cnt_nxt = count + CNT_W'(do_push) - CNT_W'(do_pop);
  assign rd_nxt  = do_pop ? inc(rd_ptr) : rd_ptr;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_comb begin
    if (clr || cnt_nxt == '0)           rdata_nxt = '0;
    else if (we && waddr == rd_nxt)     rdata_nxt = wdata;
    else                                rdata_nxt = mem[rd_nxt];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      rdata  <= '0;
    end else begin
      rd_ptr <= rd_nxt;
      if (do_push) wr_ptr <= inc(wr_ptr);
      count  <= cnt_nxt;
      rdata  <= rdata_nxt;
    end
  end

  // R6
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> (count == CNT_W'(DEPTH)));

  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    ((count == '0) && pop && !push && !clr) |=> (count == '0));

  // R9
  clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));
endmodule

// File: rtl/txstat_flags.sv
module txstat_flags (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic accept,
  input  logic fatal,
  input  logic ack,
  output logic disabled,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (rst || clr)            disabled <= 1'b0;
    else if (accept && fatal)  disabled <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         pending <= 1'b0;
    else if (accept) pending <= 1'b1;
    else if (ack)    pending <= 1'b0;
  end

  // R8
  dis_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (disabled && !clr) |=> disabled);

  // R10
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> pending);
endmodule

// File: rtl/txstat_stack.sv
module txstat_stack
  import txstat_pkg::*;
#(
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpl_valid,
  input  logic              cpl_irq_req,
  input  logic              cpl_jabber,
  input  logic              cpl_underrun,
  input  logic              cpl_maxcoll,
  input  logic              stat_wr,
  input  logic              tx_reset,
  input  logic              ack_txc,
  output logic [STAT_W-1:0] stat_rdata,
  output logic              tx_disabled,
  output logic              txc_pending
);
  logic [STAT_W-1:0] entry;
  logic              storable, fatal, accept;
  logic [CNT_W-1:0]  count;

  txstat_fmt u_fmt (
    .irq_req  (cpl_irq_req),
    .jabber   (cpl_jabber),
    .underrun (cpl_underrun),
    .maxcoll  (cpl_maxcoll),
    .entry    (entry),
    .storable (storable),
    .fatal    (fatal)
  );

  assign accept = cpl_valid && storable && !tx_disabled && !tx_reset;

  txstat_store #(
    .DEPTH   (DEPTH),
    .W       (STAT_W),
    .OVF_BIT (OVF_BIT)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .clr   (tx_reset),
    .push  (accept),
    .pop   (stat_wr),
    .din   (entry),
    .rdata (stat_rdata),
    .count (count)
  );

  txstat_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .clr      (tx_reset),
    .accept   (accept),
    .fatal    (fatal),
    .ack      (ack_txc),
    .disabled (tx_disabled),
    .pending  (txc_pending)
  );

  // R1
  empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> (stat_rdata == '0));

  // R2
  fmt_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (count != '0) |-> (stat_rdata[7] && stat_rdata[1:0] == 2'b00));
endmodule

// File: tb/txstat_stack_bench.sv
module txstat_stack_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpl_valid = 0, cpl_irq_req = 0, cpl_jabber = 0;
  logic       cpl_underrun = 0, cpl_maxcoll = 0;
  logic       stat_wr = 0, tx_reset = 0, ack_txc = 0;
  logic [7:0] stat_rdata;
  logic       tx_disabled, txc_pending;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] mq[$];
  bit         m_dis = 0, m_pend = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  txstat_stack #(.DEPTH(DEPTH)) u_txstat_stack (
    .clk(clk), .rst(rst), .cpl_valid(cpl_valid), .cpl_irq_req(cpl_irq_req),
    .cpl_jabber(cpl_jabber), .cpl_underrun(cpl_underrun),
    .cpl_maxcoll(cpl_maxcoll), .stat_wr(stat_wr), .tx_reset(tx_reset),
    .ack_txc(ack_txc), .stat_rdata(stat_rdata), .tx_disabled(tx_disabled),
    .txc_pending(txc_pending)
  );

  function automatic logic [7:0] mk(bit irq, bit jab, bit und, bit mc);
    return {1'b1, irq, jab, und, mc, 3'b000};
  endfunction

  function automatic logic [7:0] exp_rd();
    return (mq.size() == 0) ? 8'h00 : mq[0];
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit acc;
    acc = cpl_valid && !m_dis && !tx_reset &&
          (cpl_irq_req || cpl_jabber || cpl_underrun || cpl_maxcoll);
    if (tx_reset) begin
      mq.delete();
      m_dis = 0;
    end else begin
      if (stat_wr && mq.size() > 0) void'(mq.pop_front());
      if (acc) begin
        if (mq.size() < DEPTH)
          mq.push_back(mk(cpl_irq_req, cpl_jabber, cpl_underrun, cpl_maxcoll));
        else
          mq[mq.size()-1] = mq[mq.size()-1] | 8'h04;
        if (cpl_jabber || cpl_underrun) m_dis = 1;
      end
    end
    if (acc) m_pend = 1;
    else if (ack_txc) m_pend = 0;
  endtask

  task automatic cyc(bit v, bit irq, bit jab, bit und, bit mc,
                     bit wr, bit trst, bit ack, string tag);
    cpl_valid = v; cpl_irq_req = irq; cpl_jabber = jab;
    cpl_underrun = und; cpl_maxcoll = mc;
    stat_wr = wr; tx_reset = trst; ack_txc = ack;
    @(posedge clk);
    model_step();
    @(negedge clk);
    cpl_valid = 0; stat_wr = 0; tx_reset = 0; ack_txc = 0;
    chk(tag, stat_rdata, exp_rd());
    chk(tag, {7'd0, tx_disabled}, {7'd0, m_dis});
    chk(tag, {7'd0, txc_pending}, {7'd0, m_pend});
  endtask

  task automatic clean();
    cyc(0, 0, 0, 0, 0, 0, 1, 1, "R9");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R1");
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1", stat_rdata, 8'h00);
    chk("R1", {7'd0, tx_disabled}, 8'h00);
    chk("R1", {7'd0, txc_pending}, 8'h00);

    // R2 field layout: irq + maxcoll -> 0xC8
    cyc(1, 1, 0, 0, 1, 0, 0, 0, "R2");
    chk("R2", stat_rdata, 8'hC8);
    // R10 set wins over ack in same cycle
    cyc(1, 0, 0, 0, 1, 0, 0, 1, "R10");
    chk("R10", {7'd0, txc_pending}, 8'h01);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, "R10");
    chk("R10", {7'd0, txc_pending}, 8'h00);
    // R4 order: pop shows the second entry
    cyc(0, 0, 0, 0, 0, 1, 0, 0, "R4");
    chk("R4", stat_rdata, 8'h88);
    // R5 pop to empty, then pop on empty
    cyc(0, 0, 0, 0, 0, 1, 0, 0, "R5");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, "R5");
    chk("R5", stat_rdata, 8'h00);
    // R3 error-free without irq is not stored
    cyc(1, 0, 0, 0, 0, 0, 0, 0, "R3");
    chk("R3", stat_rdata, 8'h00);
    chk("R3", {7'd0, txc_pending}, 8'h00);

    // R6 fill, then overflow
    for (int i = 0; i < DEPTH; i++) cyc(1, 1, 0, 0, 0, 0, 0, 0, "R6");
    cyc(1, 0, 0, 0, 1, 0, 0, 0, "R6");
    for (int i = 0; i < DEPTH - 1; i++) cyc(0, 0, 0, 0, 0, 1, 0, 0, "R6");
    chk("R6", stat_rdata, 8'hC4);
    clean();

    // R7 pop and push together while full
    for (int i = 0; i < DEPTH; i++) cyc(1, 1, 0, 0, 0, 0, 0, 0, "R7");
    cyc(1, 0, 0, 0, 1, 1, 0, 0, "R7");
    for (int i = 0; i < DEPTH - 1; i++) cyc(0, 0, 0, 0, 0, 1, 0, 0, "R7");
    chk("R7", stat_rdata, 8'h88);
    clean();

    // R8 underrun disables, later completions ignored
    cyc(1, 0, 0, 1, 0, 0, 0, 0, "R8");
    chk("R8", {7'd0, tx_disabled}, 8'h01);
    cyc(1, 1, 1, 0, 0, 1, 0, 0, "R8");
    chk("R8", stat_rdata, 8'h00);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R8");
    chk("R8", {7'd0, tx_disabled}, 8'h01);
    // R9 reset wins over completion
    cyc(1, 1, 0, 0, 0, 0, 1, 0, "R9");
    chk("R9", stat_rdata, 8'h00);
    chk("R9", {7'd0, tx_disabled}, 8'h00);
    cyc(1, 0, 1, 0, 0, 0, 0, 0, "R8");
    chk("R8", stat_rdata, 8'hA0);
    clean();

    // random traffic, R4 ordering against the model
    for (int n = 0; n < 4000; n++) begin
      bit v, irq, jab, und, mc, wr, tr, ak;
      v   = ($urandom_range(0, 99) < 55);
      irq = ($urandom_range(0, 99) < 50);
      jab = ($urandom_range(0, 99) < 3);
      und = ($urandom_range(0, 99) < 3);
      mc  = ($urandom_range(0, 99) < 15);
      wr  = ($urandom_range(0, 99) < 40);
      tr  = ($urandom_range(0, 99) < 4);
      ak  = ($urandom_range(0, 99) < 30);
      cyc(v, irq, jab, und, mc, wr, tr, ak, "R4");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule